// File: doc/BRIEF.md
# External Data Address Generator

This unit sits between a byte-wide processor core and the memory that serves its separate external data space. That space starts at address zero and is 16 bits wide. The unit can extend the space with optional bank bits. On each access the core names a mode, a direction and a source register. The unit then forms the address, raises a request and holds it until the memory answers with ready. For reads, it returns the byte to the core's accumulator path.

The unit has two address modes. In long mode the 16-bit data pointer is the whole in-bank address. In short mode an 8-bit general register supplies the low byte, and a page register supplies the upper byte, so any 256-byte page can be reached with a single byte of pointer. Two small registers sit on the core's special-register write path: the page register and a bank register. The bank register provides extra upper address bits in both modes, for spaces above 64 KB.

Top module: `xd_addr_gen`

## Requirements
- R1: After reset `mem_req_o` and `acc_we_o` are 0, and the page and bank registers are 0, so a short access with low byte L goes to address 0x00_00L (bank 0, page 0).
- R2: A long-mode access (`acc_mode_i`=0) drives `mem_addr_o` = {bank, `dptr_i`}, for reads and for writes.
- R3: A short-mode access (`acc_mode_i`=1) drives `mem_addr_o` = {bank, page, selected register byte}. Register k occupies bits [8k+7:8k] of `gpr_i`.
- R4: With `ANY_REG`=0 (default), only bit 0 of `gpr_sel_i` is used: bit 0 = 0 selects register 0 and bit 0 = 1 selects register 1, and the upper select bits have no effect. With `ANY_REG`=1, all of `gpr_sel_i` selects the register.
- R5: A special-register write to `PAGE_ADDR` (default 0x92) loads the page register. The page affects short-mode accesses only and never long-mode addresses.
- R6: A special-register write to `BANK_ADDR` (default 0x93) loads the low `BANK_W` bits (default 2) into the bank register. These become `mem_addr_o[ADDR_W-1:16]` in both modes.
- R7: Special-register writes to any other address change neither the page nor the bank.
- R8: While `mem_req_o` is 1 and `mem_ready_i` is 0, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold their values, whatever the pointer, register, page or write-data inputs do.
- R9: Only one access is outstanding: `acc_start_i` is ignored while `busy_o` is 1.
- R10: When a read sees `mem_ready_i`, the request drops after that edge and `acc_we_o` pulses for one cycle with `acc_data_o` = the `mem_rdata_i` value sampled at that edge. A completed write produces no `acc_we_o`.
- R11: If a page write and a short-mode start fall in the same cycle, that access uses the old page, and the next access uses the new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_start_i | input | 1 | Start an access (accepted when not busy) |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_mode_i | input | 1 | 0 = long (data pointer), 1 = short (paged) |
| gpr_sel_i | input | 3 | Register index for short mode |
| gpr_i | input | 64 | Eight general registers, register k at [8k+7:8k] |
| dptr_i | input | 16 | 16-bit data pointer |
| acc_i | input | 8 | Write data from accumulator |
| sfr_we_i | input | 1 | Special-register write strobe |
| sfr_addr_i | input | 8 | Special-register write address |
| sfr_wdata_i | input | 8 | Special-register write data |
| mem_req_o | output | 1 | Request to memory |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 18 | Full address {bank, 16-bit address} |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data from memory |
| mem_ready_i | input | 1 | Memory completes the request |
| acc_data_o | output | 8 | Read byte for the accumulator |
| acc_we_o | output | 1 | One-cycle strobe for acc_data_o |
| busy_o | output | 1 | An access is outstanding |

## Verification
Two functions can coincide in one cycle: a page register write and the launch of a short-mode access. The bench provokes this by raising the special-register write strobe and the start strobe in the same cycle, with a new page value. The unit is correct if that access goes out with the previous page and the following short access uses the new one. A second overlap, a new start arriving while the bus is still stalled, is driven during an extended wait for ready. It is judged by a stable held address and by the absence of a second request after completion.

// File: rtl/xd_pkg.sv
package xd_pkg;
  typedef enum logic {
    XD_LONG  = 1'b0,
    XD_SHORT = 1'b1
  } xd_mode_e;

  localparam int unsigned XD_BYTE_W = 8;
  localparam int unsigned XD_PTR_W  = 16;
endpackage

// File: rtl/xd_page_regs.sv
module xd_page_regs #(
  parameter int unsigned BANK_W    = 2,
  parameter logic [7:0]  PAGE_ADDR = 8'h92,
  parameter logic [7:0]  BANK_ADDR = 8'h93
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sfr_we_i,
  input  logic [7:0]        sfr_addr_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic [7:0]        page_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [7:0]        page_q;
  logic [BANK_W-1:0] bank_q;
  logic              page_hit, bank_hit;

  assign page_hit = sfr_we_i && (sfr_addr_i == PAGE_ADDR);
  assign bank_hit = sfr_we_i && (sfr_addr_i == BANK_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      bank_q <= '0;
    end else begin
      if (page_hit) page_q <= sfr_wdata_i;
      if (bank_hit) bank_q <= sfr_wdata_i[BANK_W-1:0];
    end
  end

  assign page_o = page_q;
  assign bank_o = bank_q;

  a_r5_page_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_we_i && sfr_addr_i == PAGE_ADDR) |=> page_o == $past(sfr_wdata_i));
  a_r7_page_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sfr_we_i || sfr_addr_i != PAGE_ADDR) |=> $stable(page_o));
  a_r7_bank_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sfr_we_i || sfr_addr_i != BANK_ADDR) |=> $stable(bank_o));
endmodule

// File: rtl/xd_addr_mux.sv
module xd_addr_mux
  import xd_pkg::*;
#(
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned NUM_GPR = 8,
  parameter bit          ANY_REG = 1'b0,
  localparam int unsigned SEL_W  = $clog2(NUM_GPR),
  localparam int unsigned ADDR_W = XD_PTR_W + BANK_W
) (
  input  logic                   mode_i,
  input  logic [XD_PTR_W-1:0]    dptr_i,
  input  logic [NUM_GPR*8-1:0]   gpr_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [7:0]             page_i,
  input  logic [BANK_W-1:0]      bank_i,
  output logic [ADDR_W-1:0]      addr_o
);
  logic [SEL_W-1:0] idx;
  logic [7:0]       lo_byte;

  generate
    if (ANY_REG) begin : g_any
      assign idx = sel_i;
    end else begin : g_pair
      assign idx = {{(SEL_W-1){1'b0}}, sel_i[0]};
    end
  endgenerate

  assign lo_byte = gpr_i[idx*8 +: 8];

  always_comb begin
    if (xd_mode_e'(mode_i) == XD_SHORT) addr_o = {bank_i, page_i, lo_byte};
    else                                addr_o = {bank_i, dptr_i};
  end
endmodule

// File: rtl/xd_bus_ctrl.sv
module xd_bus_ctrl #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [7:0]        acc_data_o,
  output logic              acc_we_o,
  output logic              busy_o
);
  logic              req_q, we_q, acc_we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q, rdata_q;
  logic              launch, finish;

  assign launch = start_i && !req_q;
  assign finish = req_q && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      acc_we_q <= 1'b0;
    end else begin
      acc_we_q <= finish && !we_q;
      if (launch) begin
        req_q   <= 1'b1;
        we_q    <= write_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end else if (finish) begin
        req_q <= 1'b0;
        if (!we_q) rdata_q <= mem_rdata_i;
      end
    end
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign acc_data_o  = rdata_q;
  assign acc_we_o    = acc_we_q;
  assign busy_o      = req_q;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));
  a_r9_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> !mem_req_o);
  a_r10_read_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && !mem_we_o) |=> acc_we_o && acc_data_o == $past(mem_rdata_i));
  a_r10_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && mem_we_o) |=> !acc_we_o);
  a_r10_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |=> !acc_we_o);
endmodule

// File: rtl/xd_addr_gen.sv
module xd_addr_gen
  import xd_pkg::*;
#(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned NUM_GPR   = 8,
  parameter bit          ANY_REG   = 1'b0,
  parameter logic [7:0]  PAGE_ADDR = 8'h92,
  parameter logic [7:0]  BANK_ADDR = 8'h93,
  localparam int unsigned SEL_W    = $clog2(NUM_GPR),
  localparam int unsigned ADDR_W   = XD_PTR_W + BANK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_start_i,
  input  logic                 acc_write_i,
  input  logic                 acc_mode_i,
  input  logic [SEL_W-1:0]     gpr_sel_i,
  input  logic [NUM_GPR*8-1:0] gpr_i,
  input  logic [XD_PTR_W-1:0]  dptr_i,
  input  logic [7:0]           acc_i,
  input  logic                 sfr_we_i,
  input  logic [7:0]           sfr_addr_i,
  input  logic [7:0]           sfr_wdata_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [7:0]           mem_wdata_o,
  input  logic [7:0]           mem_rdata_i,
  input  logic                 mem_ready_i,
  output logic [7:0]           acc_data_o,
  output logic                 acc_we_o,
  output logic                 busy_o
);
  logic [7:0]        page;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] next_addr;

  xd_page_regs #(
    .BANK_W(BANK_W), .PAGE_ADDR(PAGE_ADDR), .BANK_ADDR(BANK_ADDR)
  ) i_regs (
    .clk_i, .rst_ni, .sfr_we_i, .sfr_addr_i, .sfr_wdata_i,
    .page_o(page), .bank_o(bank)
  );

  xd_addr_mux #(
    .BANK_W(BANK_W), .NUM_GPR(NUM_GPR), .ANY_REG(ANY_REG)
  ) i_mux (
    .mode_i(acc_mode_i), .dptr_i, .gpr_i, .sel_i(gpr_sel_i),
    .page_i(page), .bank_i(bank), .addr_o(next_addr)
  );

  xd_bus_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i, .rst_ni,
    .start_i(acc_start_i), .write_i(acc_write_i),
    .addr_i(next_addr), .wdata_i(acc_i),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ready_i,
    .acc_data_o, .acc_we_o, .busy_o
  );

  a_r2_long_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_start_i && !busy_o && acc_mode_i == XD_LONG)
      |=> mem_addr_o[XD_PTR_W-1:0] == $past(dptr_i));
  a_r6_bank_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_start_i && !busy_o) |=> mem_addr_o[ADDR_W-1:XD_PTR_W] == $past(bank));
endmodule

// File: tb/test_xd_addr_gen.sv
module test_xd_addr_gen;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, wr = 0, mode = 0;
  logic [2:0]  sel = 0;
  logic [63:0] gpr = 0;
  logic [15:0] dptr = 0;
  logic [7:0]  acc = 0;
  logic        sfr_we = 0;
  logic [7:0]  sfr_addr = 0, sfr_wdata = 0;
  logic        req, we;
  logic [17:0] addr;
  logic [7:0]  wdata, rdata = 0, acc_data;
  logic        ready = 0, acc_we, busy;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  xd_addr_gen i_xd_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .acc_start_i(start), .acc_write_i(wr),
    .acc_mode_i(mode), .gpr_sel_i(sel), .gpr_i(gpr), .dptr_i(dptr), .acc_i(acc),
    .sfr_we_i(sfr_we), .sfr_addr_i(sfr_addr), .sfr_wdata_i(sfr_wdata),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_ready_i(ready), .acc_data_o(acc_data),
    .acc_we_o(acc_we), .busy_o(busy)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sfr_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); sfr_we = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_we = 0;
  endtask

  // Launch one access, check address, complete after 'waits' stalled cycles.
  task automatic access(string tag, logic m, logic w, logic [2:0] s,
                        logic [17:0] exp_addr, logic [7:0] rd, int waits);
    @(negedge clk); start = 1; mode = m; wr = w; sel = s;
    step();
    check({tag, " req"}, {31'b0, req}, 1);
    check({tag, " addr"}, {14'b0, addr}, {14'b0, exp_addr});
    check({tag, " we"}, {31'b0, we}, {31'b0, w});
    @(negedge clk); start = 0;
    for (int i = 0; i < waits; i++) step();
    @(negedge clk); ready = 1; rdata = rd;
    step();
    check({tag, " req drop"}, {31'b0, req}, 0);
    check({tag, " acc_we"}, {31'b0, acc_we}, {31'b0, !w});
    if (!w) check({tag, " acc_data"}, {24'b0, acc_data}, {24'b0, rd});
    @(negedge clk); ready = 0;
    step();
    check({tag, " acc_we one pulse"}, {31'b0, acc_we}, 0);
  endtask

  task automatic t_reset();
    check("R1 req reset", {31'b0, req}, 0);
    check("R1 acc_we reset", {31'b0, acc_we}, 0);
    check("R1 busy reset", {31'b0, busy}, 0);
    gpr[15:8] = 8'h3C;
    access("R1 short after reset", 1, 0, 3'd1, 18'h0003C, 8'h11, 0);
  endtask

  task automatic t_long();
    dptr = 16'hBEEF;
    access("R2 long read", 0, 0, 3'd0, 18'h0BEEF, 8'hA5, 1);
    dptr = 16'h0102; acc = 8'h77;
    access("R2 long write", 0, 1, 3'd0, 18'h00102, 8'h00, 0);
    check("R2 write data", {24'b0, wdata}, 32'h77);
  endtask

  task automatic t_short_sel();
    gpr[7:0] = 8'h10; gpr[15:8] = 8'h21; gpr[47:40] = 8'h55;
    access("R3 short r0", 1, 0, 3'd0, 18'h00010, 8'h01, 0);
    access("R4 sel 5 masks to r1", 1, 0, 3'd5, 18'h00021, 8'h02, 0);
    access("R4 sel 4 masks to r0", 1, 1, 3'd4, 18'h00010, 8'h00, 0);
  endtask

  task automatic t_page();
    sfr_write(8'h92, 8'hC4);
    access("R5 short paged", 1, 0, 3'd1, 18'h0C421, 8'h03, 0);
    dptr = 16'h0040;
    access("R5 long ignores page", 0, 0, 3'd0, 18'h00040, 8'h04, 0);
  endtask

  task automatic t_bank();
    sfr_write(8'h93, 8'hFE); // low 2 bits = 2
    access("R6 bank long", 0, 0, 3'd0, 18'h20040, 8'h05, 0);
    access("R6 bank short", 1, 1, 3'd0, 18'h2C410, 8'h00, 0);
  endtask

  task automatic t_ignored();
    sfr_write(8'h91, 8'h00);
    sfr_write(8'h94, 8'h01);
    access("R7 page/bank unchanged", 1, 0, 3'd1, 18'h2C421, 8'h06, 0);
  endtask

  task automatic t_hold_busy();
    dptr = 16'h1234; acc = 8'h9A;
    @(negedge clk); start = 1; mode = 0; wr = 1;
    step();
    check("R8 launch addr", {14'b0, addr}, {14'b0, 18'h21234});
    @(negedge clk);
    dptr = 16'hFFFF; acc = 8'h00; gpr = '1; wr = 0; mode = 1;
    sfr_write(8'h92, 8'h00);
    @(negedge clk); start = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R8 addr held", {14'b0, addr}, {14'b0, 18'h21234});
      check("R8 we held", {31'b0, we}, 1);
      check("R8 wdata held", {24'b0, wdata}, 32'h9A);
      check("R9 still one request", {31'b0, busy}, 1);
    end
    @(negedge clk); start = 0; ready = 1;
    step();
    check("R10 write no acc_we", {31'b0, acc_we}, 0);
    @(negedge clk); ready = 0;
    step();
    check("R9 no queued access", {31'b0, req}, 0);
  endtask

  task automatic t_same_cycle();
    gpr[7:0] = 8'h80;
    @(negedge clk);
    sfr_we = 1; sfr_addr = 8'h92; sfr_wdata = 8'h5A;
    start = 1; mode = 1; wr = 0; sel = 3'd0;
    step();
    check("R11 old page used", {14'b0, addr}, {14'b0, 18'h20080});
    @(negedge clk); sfr_we = 0; start = 0; ready = 1; rdata = 8'h07;
    step();
    check("R11 read done", {24'b0, acc_data}, 32'h07);
    @(negedge clk); ready = 0;
    access("R11 new page next", 1, 0, 3'd0, 18'h25A80, 8'h08, 0);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #20 rst_n = 1;
    step();
    t_reset();
    t_long();
    t_short_sel();
    t_page();
    t_bank();
    t_ignored();
    t_hold_busy();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule